// File: doc/BRIEF.md
# Tiled Surface Address Calculator

This block turns integer texel coordinates into a byte offset inside a surface stored in memory as tiles, as a flat pitch-linear array, or as a stack of slices. Every transaction carries its own surface description: a per-axis base offset, a row pitch in texels, a byte size per texel, log2 tile sizes for both axes, a log2 slice grouping with horizontal and vertical slice steps, two run-time swizzle shift amounts and a swizzle enable. A surface whose tiles are tall and narrow is described as a row of narrow tiles, each one a 512-byte column of a 4 KB tile. Slices of a three-dimensional or array surface are folded into extra x and y displacement before the tile arithmetic runs.

A caller raises `in_valid` with the coordinates and the surface fields for one cycle per request. The result appears on `out_offset` with `out_valid` exactly three clock cycles later. A new request may be issued on every cycle. The address swizzle flips bit 6 of the offset by the XOR of two bits taken from the offset itself. It is switched off either with the enable input or by giving both shift amounts a value of 31 or more.

Top module: `tiled_addr_calc`

## Requirements
- R1: Every cycle with `in_valid` high yields exactly one cycle with `out_valid` high three rising edges later, in issue order and at full throughput. `out_valid` is never high otherwise.
- R2: `dims_sel` values 0 and 1 select one dimension, 2 selects two and 3 selects three. `coord_y` is ignored below two dimensions and `coord_z` is ignored below three. `base_x` is added to x and `base_y` is added to y before any other arithmetic.
- R3: With three dimensions, the low `slice_log2` bits of z times `slice_step_x` are added to x. z shifted right by `slice_log2`, times `slice_step_y`, is added to y.
- R4: With two or more dimensions, each axis splits into minor = low `tile_log2` bits and major = coordinate shifted right by `tile_log2`. The offset before swizzle is (((major_x << tile_log2_y) + minor_y) << tile_log2_x) + minor_x + ((major_y << tile_log2_y) * row_pitch), all multiplied by `bytes_pp`.
- R5: With one dimension, the offset is (x + y * row_pitch) * bytes_pp, where y is `base_y` alone.
- R6: With two or more dimensions and `swz_enable` high, bit 6 of the offset is inverted when bit 6 of (offset >> swz_sh_a) differs from bit 6 of (offset >> swz_sh_b). No other bit changes.
- R7: A shift amount of 31 or more, including 0xff, makes its shifted term zero. With both swizzle shifts at 0xff the offset is unchanged.
- R8: With `swz_enable` low, or with one dimension, no swizzle is applied.
- R9: `out_offset` keeps its last value in cycles where `out_valid` is low.
- R10: All arithmetic is 32-bit unsigned modulo 2^32. Any left or right shift by 31 or more gives zero. A `bytes_pp` of zero gives an offset of zero.
- R11: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe |
| dims_sel | input | 2 | Dimensionality of the request |
| coord_x | input | 32 | Texel x |
| coord_y | input | 32 | Texel y |
| coord_z | input | 32 | Slice index |
| base_x | input | 32 | Base x offset |
| base_y | input | 32 | Base y offset |
| row_pitch | input | 32 | Texels per row multiplier |
| slice_step_x | input | 32 | Horizontal step per minor slice |
| slice_step_y | input | 32 | Vertical step per major slice |
| bytes_pp | input | 32 | Bytes per texel |
| tile_log2_x | input | 5 | log2 of tile width |
| tile_log2_y | input | 5 | log2 of tile height |
| slice_log2 | input | 5 | log2 of slices per slice row |
| swz_sh_a | input | 8 | First swizzle shift |
| swz_sh_b | input | 8 | Second swizzle shift |
| swz_enable | input | 1 | Swizzle stage enable |
| out_valid | output | 1 | Result strobe |
| out_offset | output | 32 | Byte offset |

## Verification
The assertions assume that `in_valid` and `bytes_pp` are known, with no X or Z, at every sampled rising edge after reset. They also assume that `rst_n` is released away from a clock edge. The surface fields need not stay constant while a request is in flight, because each stage carries its own copy. The stimulus changes every input only on falling edges, starts from defined values at time zero, and holds reset across several edges.

// File: rtl/tac_pkg.sv
`timescale 1ns/1ps
package tac_pkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned SWZ_W  = 8;
  localparam int unsigned SH_W    = $clog2(WORD_W);
  localparam int unsigned SAT_SH  = WORD_W - 1;
  localparam int unsigned FLIP_AT = 6;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SH_W-1:0]   tsh_t;
  typedef logic [SWZ_W-1:0]  swsh_t;

  typedef struct packed {
    word_t ax;
    word_t ay;
    word_t pitch;
    word_t bpp;
    logic  two_d;
    tsh_t  tlx;
    tsh_t  tly;
    swsh_t sa;
    swsh_t sb;
    logic  swz_on;
  } fold_t;

  typedef struct packed {
    word_t lin;
    word_t bpp;
    logic  two_d;
    swsh_t sa;
    swsh_t sb;
    logic  swz_on;
  } tile_t;

  function automatic word_t shr_sat(input word_t v, input int n);
    return (n >= int'(SAT_SH)) ? '0 : (v >> n);
  endfunction

  function automatic word_t shl_sat(input word_t v, input int n);
    return (n >= int'(SAT_SH)) ? '0 : (v << n);
  endfunction

  function automatic word_t low_bits(input word_t v, input int n);
    return (n >= int'(WORD_W)) ? v : (v & ((word_t'(1) << n) - word_t'(1)));
  endfunction
endpackage

// File: rtl/tac_fold.sv
`timescale 1ns/1ps
module tac_fold
  import tac_pkg::*;
(
  input  logic [1:0] dims,
  input  word_t      cx,
  input  word_t      cy,
  input  word_t      cz,
  input  word_t      bx,
  input  word_t      by,
  input  word_t      pitch,
  input  word_t      step_x,
  input  word_t      step_y,
  input  word_t      bpp,
  input  tsh_t       tlx,
  input  tsh_t       tly,
  input  tsh_t       tlz,
  input  swsh_t      sa,
  input  swsh_t      sb,
  input  logic       swz_en,
  output fold_t      f
);
  word_t y_used;
  word_t z_lo;
  word_t z_hi;
  word_t x_sum;
  word_t y_sum;

  always_comb begin
    y_used = (dims >= 2'd2) ? cy : '0;
    z_lo   = low_bits(cz, int'(tlz));
    z_hi   = shr_sat(cz, int'(tlz));
    x_sum  = bx + cx;
    y_sum  = by + y_used;
    if (dims == 2'd3) begin
      x_sum = x_sum + z_lo * step_x;
      y_sum = y_sum + z_hi * step_y;
    end
    f.ax     = x_sum;
    f.ay     = y_sum;
    f.pitch  = pitch;
    f.bpp    = bpp;
    f.two_d  = (dims >= 2'd2);
    f.tlx    = tlx;
    f.tly    = tly;
    f.sa     = sa;
    f.sb     = sb;
    f.swz_on = swz_en;
  end
endmodule

// File: rtl/tac_tile.sv
`timescale 1ns/1ps
module tac_tile
  import tac_pkg::*;
(
  input  fold_t f,
  output tile_t t
);
  localparam int unsigned AXES = 2;

  word_t crd [AXES];
  tsh_t  shv [AXES];
  word_t mnr [AXES];
  word_t mjr [AXES];

  assign crd[0] = f.ax;
  assign crd[1] = f.ay;
  assign shv[0] = f.tlx;
  assign shv[1] = f.tly;

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    assign mnr[g] = low_bits(crd[g], int'(shv[g]));
    assign mjr[g] = shr_sat(crd[g], int'(shv[g]));
  end

  word_t in_row;
  word_t row_base;

  always_comb begin
    in_row   = shl_sat(shl_sat(mjr[0], int'(f.tly)) + mnr[1], int'(f.tlx)) + mnr[0];
    row_base = shl_sat(mjr[1], int'(f.tly)) * f.pitch;
    t.lin    = f.two_d ? (in_row + row_base) : (f.ax + f.ay * f.pitch);
    t.bpp    = f.bpp;
    t.two_d  = f.two_d;
    t.sa     = f.sa;
    t.sb     = f.sb;
    t.swz_on = f.swz_on;
  end
endmodule

// File: rtl/tac_swz.sv
`timescale 1ns/1ps
module tac_swz
  import tac_pkg::*;
(
  input  tile_t t,
  output word_t off
);
  localparam word_t FLIP_MASK = word_t'(1) << FLIP_AT;

  word_t bytes;
  word_t flip;

  always_comb begin
    bytes = t.lin * t.bpp;
    flip  = (shr_sat(bytes, int'(t.sa)) ^ shr_sat(bytes, int'(t.sb))) & FLIP_MASK;
    off   = (t.two_d && t.swz_on) ? (bytes ^ flip) : bytes;
  end
endmodule

// File: rtl/tiled_addr_calc.sv
`timescale 1ns/1ps
module tiled_addr_calc
  import tac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  dims_sel,
  input  logic [31:0] coord_x,
  input  logic [31:0] coord_y,
  input  logic [31:0] coord_z,
  input  logic [31:0] base_x,
  input  logic [31:0] base_y,
  input  logic [31:0] row_pitch,
  input  logic [31:0] slice_step_x,
  input  logic [31:0] slice_step_y,
  input  logic [31:0] bytes_pp,
  input  logic [4:0]  tile_log2_x,
  input  logic [4:0]  tile_log2_y,
  input  logic [4:0]  slice_log2,
  input  logic [7:0]  swz_sh_a,
  input  logic [7:0]  swz_sh_b,
  input  logic        swz_enable,
  output logic        out_valid,
  output logic [31:0] out_offset
);
  fold_t fold_d, fold_q;
  tile_t tile_d, tile_q;
  word_t off_d,  off_q;
  logic  v1_q, v2_q, v3_q;
  logic  v1_d, v2_d, v3_d;
  logic  ld1, ld2, ld3;

  tac_fold u_fold (
    .dims   (dims_sel),
    .cx     (coord_x),
    .cy     (coord_y),
    .cz     (coord_z),
    .bx     (base_x),
    .by     (base_y),
    .pitch  (row_pitch),
    .step_x (slice_step_x),
    .step_y (slice_step_y),
    .bpp    (bytes_pp),
    .tlx    (tile_log2_x),
    .tly    (tile_log2_y),
    .tlz    (slice_log2),
    .sa     (swz_sh_a),
    .sb     (swz_sh_b),
    .swz_en (swz_enable),
    .f      (fold_d)
  );

  tac_tile u_tile (
    .f (fold_q),
    .t (tile_d)
  );

  tac_swz u_swz (
    .t   (tile_q),
    .off (off_d)
  );

  // next state and clock enables
  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
    v3_d = v2_q;
    ld1  = in_valid;
    ld2  = v1_q;
    ld3  = v2_q;
  end

  // valid pipeline, reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      v3_q <= v3_d;
    end
  end

  // data pipeline, enabled, no reset
  always_ff @(posedge clk) begin
    if (ld1) fold_q <= fold_d;
    if (ld2) tile_q <= tile_d;
    if (ld3) off_q  <= off_d;
  end

  assign out_valid  = v3_q;
  assign out_offset = off_q;
endmodule

// File: rtl/tac_chk.sv
`timescale 1ns/1ps
module tac_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] bytes_pp,
  input logic        out_valid,
  input logic [31:0] out_offset
);
  logic [2:0] vtrk;
  logic [2:0] ztrk;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vtrk <= '0;
      ztrk <= '0;
      seen <= 1'b0;
    end else begin
      vtrk <= {vtrk[1:0], in_valid};
      ztrk <= {ztrk[1:0], in_valid && (bytes_pp == 32'd0)};
      seen <= seen | out_valid;
    end
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vtrk[2]);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !out_valid) |-> $stable(out_offset));

  a_r10_zero_bpp: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ztrk[2]) |-> (out_offset == 32'd0));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r11_reset_idle: assert (!out_valid);
    end
  end
endmodule

bind tiled_addr_calc tac_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .bytes_pp   (bytes_pp),
  .out_valid  (out_valid),
  .out_offset (out_offset)
);

// File: tb/tiled_addr_calc_tb_top.sv
`timescale 1ns/1ps
module tiled_addr_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  dims_sel = '0;
  logic [31:0] coord_x = '0, coord_y = '0, coord_z = '0;
  logic [31:0] base_x = '0, base_y = '0, row_pitch = '0;
  logic [31:0] slice_step_x = '0, slice_step_y = '0, bytes_pp = '0;
  logic [4:0]  tile_log2_x = '0, tile_log2_y = '0, slice_log2 = '0;
  logic [7:0]  swz_sh_a = '0, swz_sh_b = '0;
  logic        swz_enable = 1'b0;
  logic        out_valid;
  logic [31:0] out_offset;

  // staged request
  int          s_d;
  logic [31:0] s_x, s_y, s_z, s_bx, s_by, s_p, s_sx, s_sy, s_bpp;
  int          s_tx, s_ty, s_tz, s_a, s_b;
  bit          s_en;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit seen_out = 0;
  logic [31:0] last_out = '0;

  bit          qv[$];
  logic [31:0] qd[$];
  string       qt[$];

  always #2 clk = ~clk;

  tiled_addr_calc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dims_sel(dims_sel),
    .coord_x(coord_x), .coord_y(coord_y), .coord_z(coord_z),
    .base_x(base_x), .base_y(base_y), .row_pitch(row_pitch),
    .slice_step_x(slice_step_x), .slice_step_y(slice_step_y),
    .bytes_pp(bytes_pp), .tile_log2_x(tile_log2_x), .tile_log2_y(tile_log2_y),
    .slice_log2(slice_log2), .swz_sh_a(swz_sh_a), .swz_sh_b(swz_sh_b),
    .swz_enable(swz_enable), .out_valid(out_valid), .out_offset(out_offset)
  );

  localparam longint unsigned MOD = 64'h1_0000_0000;

  function automatic longint unsigned p2(int n);
    return longint'(1) << n;
  endfunction
  function automatic longint unsigned rsh(longint unsigned v, int n);
    return (n >= 31) ? 0 : v / p2(n);
  endfunction
  function automatic longint unsigned lsh(longint unsigned v, int n);
    return (n >= 31) ? 0 : (v * p2(n)) % MOD;
  endfunction

  function automatic logic [31:0] ref_calc();
    longint unsigned ax, ay, ix, row, lin, off, ba, bb;
    ax = (longint'(s_bx) + s_x) % MOD;
    ay = (longint'(s_by) + ((s_d >= 2) ? longint'(s_y) : 0)) % MOD;
    if (s_d == 3) begin
      ax = (ax + (longint'(s_z) % p2(s_tz)) * s_sx % MOD) % MOD;
      ay = (ay + (rsh(s_z, s_tz) * s_sy) % MOD) % MOD;
    end
    if (s_d >= 2) begin
      ix  = lsh((lsh(rsh(ax, s_tx), s_ty) + ay % p2(s_ty)) % MOD, s_tx);
      ix  = (ix + ax % p2(s_tx)) % MOD;
      row = (lsh(rsh(ay, s_ty), s_ty) * s_p) % MOD;
      lin = (ix + row) % MOD;
    end else begin
      lin = (ax + (ay * s_p) % MOD) % MOD;
    end
    off = (lin * s_bpp) % MOD;
    if (s_en && s_d >= 2) begin
      ba = (rsh(off, s_a) / 64) % 2;
      bb = (rsh(off, s_b) / 64) % 2;
      if (ba != bb) off = off ^ 64;
    end
    return off[31:0];
  endfunction

  task automatic check_due();
    bit ev; logic [31:0] ed; string et;
    if (qv.size() < 3) return;
    ev = qv.pop_front(); ed = qd.pop_front(); et = qt.pop_front();
    total++;
    if (out_valid !== ev) begin
      bad++;
      $display("FAIL R1: out_valid=%0b expected=%0b", out_valid, ev);
    end
    if (ev) begin
      total++;
      if (out_offset !== ed) begin
        bad++;
        $display("FAIL %s: out_offset=%h expected=%h", et, out_offset, ed);
      end
      last_out = ed;
      seen_out = 1;
    end else if (seen_out) begin
      total++;
      if (out_offset !== last_out) begin
        bad++;
        $display("FAIL R9: out_offset=%h expected held=%h", out_offset, last_out);
      end
    end
  endtask

  task automatic issue(string tag);
    @(negedge clk);
    check_due();
    in_valid = 1'b1; dims_sel = 2'(s_d);
    coord_x = s_x; coord_y = s_y; coord_z = s_z;
    base_x = s_bx; base_y = s_by; row_pitch = s_p;
    slice_step_x = s_sx; slice_step_y = s_sy; bytes_pp = s_bpp;
    tile_log2_x = 5'(s_tx); tile_log2_y = 5'(s_ty); slice_log2 = 5'(s_tz);
    swz_sh_a = 8'(s_a); swz_sh_b = 8'(s_b); swz_enable = s_en;
    qv.push_back(1'b1); qd.push_back(ref_calc()); qt.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_due();
      in_valid = 1'b0;
      coord_x = 32'hdead_beef;
      qv.push_back(1'b0); qd.push_back('0); qt.push_back("R1");
    end
  endtask

  task automatic defaults();
    s_d = 2; s_x = 0; s_y = 0; s_z = 0; s_bx = 0; s_by = 0; s_p = 64;
    s_sx = 0; s_sy = 0; s_bpp = 4; s_tx = 3; s_ty = 3; s_tz = 0;
    s_a = 8'hff; s_b = 8'hff; s_en = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    defaults();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin
        bad++;
        $display("FAIL R11: out_valid=%0b expected=0", out_valid);
      end
    end
    rst_n = 1'b1;
    idle(3);

    // R5 and R2: one-dimensional, y input ignored, base_y used; (15+200)*4
    defaults(); s_d = 1; s_x = 5; s_bx = 10; s_y = 99; s_by = 2; s_p = 100;
    issue("R5");
    s_d = 0; issue("R2");
    // R2: two-dimensional ignores z
    defaults(); s_x = 17; s_y = 9; s_z = 77; s_sx = 5; s_sy = 5; s_bx = 3; s_by = 1;
    issue("R2");
    // R4: wide tiles and narrow tall tiles
    defaults(); s_x = 27; s_y = 13; issue("R4");
    defaults(); s_tx = 4; s_ty = 5; s_x = 300; s_y = 70; s_p = 256; issue("R4");
    defaults(); s_tx = 9; s_ty = 3; s_x = 1000; s_y = 21; s_p = 2048; s_bpp = 1; issue("R4");
    // R3: slice folding
    defaults(); s_d = 3; s_tz = 2; s_z = 11; s_sx = 16; s_sy = 32; s_x = 4; s_y = 6;
    issue("R3");
    s_tz = 0; s_z = 5; issue("R3");
    // R6: swizzle with live shifts
    for (int i = 0; i < 12; i++) begin
      defaults(); s_en = 1; s_a = 3; s_b = 4 + (i % 3);
      s_x = $urandom_range(0, 4095); s_y = $urandom_range(0, 4095);
      issue("R6");
    end
    // R7: saturating shifts
    defaults(); s_en = 1; s_a = 8'hff; s_b = 8'hff; s_x = 123; s_y = 45; issue("R7");
    s_a = 31; s_b = 9; issue("R7");
    s_a = 40; s_b = 0; issue("R7");
    s_a = 0; s_b = 0; s_tx = 31; issue("R10");
    // R8: enable low, and one dimension with enable high
    defaults(); s_a = 3; s_b = 4; s_x = 200; s_y = 77; issue("R8");
    s_d = 1; s_en = 1; issue("R8");
    idle(2);
    // R10: wraparound and zero bytes per texel
    defaults(); s_d = 1; s_bx = 32'hffff_fff0; s_x = 32'h40; s_bpp = 32'h1000_0000; issue("R10");
    defaults(); s_bpp = 0; s_x = 999; s_y = 999; s_en = 1; s_a = 2; issue("R10");
    defaults(); s_d = 3; s_z = 32'hffff_ffff; s_tz = 3; s_sx = 32'h8000_0001;
    s_sy = 32'h7fff_ffff; s_p = 32'hffff_fff1; issue("R10");
    idle(5);
    // R1: back-to-back and gapped random traffic
    for (int i = 0; i < 200; i++) begin
      defaults();
      s_d = $urandom_range(0, 3); s_x = $urandom; s_y = $urandom; s_z = $urandom;
      s_bx = $urandom; s_by = $urandom; s_p = $urandom; s_sx = $urandom;
      s_sy = $urandom; s_bpp = $urandom_range(0, 16);
      s_tx = $urandom_range(0, 31); s_ty = $urandom_range(0, 31);
      s_tz = $urandom_range(0, 31); s_a = $urandom_range(0, 255);
      s_b = $urandom_range(0, 40); s_en = 1'($urandom_range(0, 1));
      issue("R1");
      if ((i % 7) == 3) idle($urandom_range(1, 3));
    end
    idle(6);
    summary();
  end
endmodule